// File: doc/BRIEF.md
# Masked vector compress unit

This block gathers the selected elements of a 512-bit source vector and packs them, in their original order, into the lowest positions of the result. Elements are either bytes or 16-bit words, and the operation covers a chosen vector span of 128, 256 or 512 bits. A 64-bit mask picks the elements. A mask-enable input turns the mask off so that every element inside the span is taken.

Each transaction produces two forms of the result at once. The register form is a full 512-bit value. Its tail above the packed elements is either kept from a supplied old destination (merging) or cleared (zeroing), and everything above the span is zero. The store form gives the packed bytes together with a 64-bit byte-enable vector that covers only the packed bytes. A consumer that writes to memory uses the enables and leaves every other byte untouched. The zeroing input is expected to be low whenever the store form is the one being used.

Inputs are captured on a valid strobe. All outputs, including the number of packed elements, appear from registers together with an output valid one clock later.

Top module: `vcompress_unit`

## Requirements
- R1: Source elements are walked from index 0 upward. Each active element goes to the next free result slot, starting at slot 0, so the relative order of the active elements is preserved.
- R2: The span select encodes 0 = 128 bits, 1 = 256 bits and 2 or 3 = 512 bits. This gives 16/32/64 elements for bytes (in_word = 0) and 8/16/32 elements for words (in_word = 1). Mask bit i selects element i. Mask bits at or above the element count have no effect on any output.
- R3: With in_mask_en low, every element in the span is active. The register result then equals the source within the span, and the count equals the element count.
- R4: With in_zero low, register-result bytes from (count × element bytes) up to the span are copied from in_old.
- R5: With in_zero high, register-result bytes from (count × element bytes) up to the span are zero.
- R6: Register-result bytes at or above the span are zero in both tail modes.
- R7: The store form sets out_byte_en bit b exactly when b < count × element bytes. Bit b of the enable vector covers out_store_data bits [8b+7:8b]. Those store bytes hold the packed data, and every byte without an enable is zero.
- R8: out_count gives the number of active elements, from 0 to 64.
- R9: An all-zero mask with in_mask_en high gives a count of 0 and no byte enables. The register result is then in_old (merging) or zero (zeroing) within the span.
- R10: After an asynchronous active-low reset, out_valid is 0, and out_result, out_store_data, out_byte_en and out_count are all zero. out_valid is high exactly one clock after a cycle with in_valid high. Outputs hold their values while in_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture strobe for all operand inputs |
| in_src | input | 512 | Source vector, byte b at bits [8b+7:8b] |
| in_old | input | 512 | Prior destination value used for merging |
| in_mask | input | 64 | Element select mask, bit i for element i |
| in_mask_en | input | 1 | 1 = apply mask, 0 = all elements active |
| in_word | input | 1 | 0 = byte elements, 1 = 16-bit elements |
| in_vsel | input | 2 | Span select (0: 128, 1: 256, 2/3: 512 bits) |
| in_zero | input | 1 | 1 = clear tail, 0 = merge tail from in_old |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| out_result | output | 512 | Register-form result |
| out_store_data | output | 512 | Store-form packed data, zero beyond packed bytes |
| out_byte_en | output | 64 | Store-form byte enables |
| out_count | output | 7 | Number of packed elements |

## Verification
The assertions take for granted that in_valid and the operand inputs are stable around the rising edge. They also take for granted that in_valid is low while reset is asserted, so the valid-follows checks start from a clean pipeline. The bench drives every input on the falling edge and holds in_valid low through reset. It drives only span codes 0 to 2, so the element-count bound in the checks is always reached through an encoding the bench also models. Zeroing stays within the stated rule because the store-form outputs are checked against the packed region only, whatever the tail mode.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
  parameter int unsigned VEC_BITS  = 512;
  localparam int unsigned VEC_BYTES = VEC_BITS / 8;
  localparam int unsigned CNT_W     = $clog2(VEC_BYTES) + 1;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    SPAN_Q    = 2'd0,
    SPAN_H    = 2'd1,
    SPAN_F    = 2'd2,
    SPAN_F_AL = 2'd3
  } span_e;

  // bytes covered by a span code
  function automatic cnt_t span_bytes(input logic [1:0] vsel);
    case (span_e'(vsel))
      SPAN_Q:  return cnt_t'(VEC_BYTES / 4);
      SPAN_H:  return cnt_t'(VEC_BYTES / 2);
      default: return cnt_t'(VEC_BYTES);
    endcase
  endfunction
endpackage

// File: rtl/vcmp_lane_sel.sv
module vcmp_lane_sel
  import vcmp_pkg::*;
(
  input  logic [VEC_BYTES-1:0] mask,
  input  logic                 mask_en,
  input  logic                 word,
  input  logic [1:0]           vsel,
  output logic [VEC_BYTES-1:0] byte_sel,
  output cnt_t                 span
);
  assign span = span_bytes(vsel);

  // byte-granular activity: word elements drive both of their bytes
  for (genvar g = 0; g < VEC_BYTES; g++) begin : g_lane
    localparam int unsigned WIDX = g / 2;
    logic in_span;
    logic elem_bit;
    assign in_span     = cnt_t'(g) < span;
    assign elem_bit    = word ? mask[WIDX] : mask[g];
    assign byte_sel[g] = in_span & (~mask_en | elem_bit);
  end
endmodule

// File: rtl/vcmp_pack.sv
module vcmp_pack
  import vcmp_pkg::*;
(
  input  logic [VEC_BITS-1:0]  src,
  input  logic [VEC_BYTES-1:0] byte_sel,
  output logic [VEC_BITS-1:0]  packed_q,
  output cnt_t                 pk_bytes
);
  logic [VEC_BYTES-1:0][CNT_W-1:0] dest;
  cnt_t acc;

  // running count of selected bytes below each position = its destination slot
  always_comb begin
    acc = '0;
    for (int j = 0; j < VEC_BYTES; j++) begin
      dest[j] = acc;
      acc     = acc + cnt_t'(byte_sel[j]);
    end
    pk_bytes = acc;
  end

  // each output slot ORs in the one source byte routed to it
  always_comb begin
    packed_q = '0;
    for (int k = 0; k < VEC_BYTES; k++) begin
      for (int j = k; j < VEC_BYTES; j++) begin
        if (byte_sel[j] && (dest[j] == cnt_t'(k))) begin
          packed_q[k*8 +: 8] = packed_q[k*8 +: 8] | src[j*8 +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/vcmp_tail.sv
module vcmp_tail
  import vcmp_pkg::*;
(
  input  logic [VEC_BITS-1:0]  packed_q,
  input  logic [VEC_BITS-1:0]  old,
  input  cnt_t                 pk_bytes,
  input  cnt_t                 span,
  input  logic                 zero,
  output logic [VEC_BITS-1:0]  result,
  output logic [VEC_BITS-1:0]  store_data,
  output logic [VEC_BYTES-1:0] byte_en
);
  for (genvar g = 0; g < VEC_BYTES; g++) begin : g_byte
    logic in_pk;
    logic in_span;
    assign in_pk   = cnt_t'(g) < pk_bytes;
    assign in_span = cnt_t'(g) < span;
    assign result[g*8 +: 8] = in_pk              ? packed_q[g*8 +: 8] :
                              (in_span && !zero) ? old[g*8 +: 8]      : 8'h00;
    assign store_data[g*8 +: 8] = in_pk ? packed_q[g*8 +: 8] : 8'h00;
    assign byte_en[g]           = in_pk;
  end
endmodule

// File: rtl/vcompress_unit.sv
module vcompress_unit
  import vcmp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [VEC_BITS-1:0]  in_src,
  input  logic [VEC_BITS-1:0]  in_old,
  input  logic [VEC_BYTES-1:0] in_mask,
  input  logic                 in_mask_en,
  input  logic                 in_word,
  input  logic [1:0]           in_vsel,
  input  logic                 in_zero,
  output logic                 out_valid,
  output logic [VEC_BITS-1:0]  out_result,
  output logic [VEC_BITS-1:0]  out_store_data,
  output logic [VEC_BYTES-1:0] out_byte_en,
  output logic [CNT_W-1:0]     out_count
);
  logic [VEC_BYTES-1:0] byte_sel;
  cnt_t                 span;
  logic [VEC_BITS-1:0]  packed_q;
  cnt_t                 pk_bytes;
  logic [VEC_BITS-1:0]  c_result;
  logic [VEC_BITS-1:0]  c_store;
  logic [VEC_BYTES-1:0] c_be;
  cnt_t                 c_cnt;

  vcmp_lane_sel u_sel (
    .mask     (in_mask),
    .mask_en  (in_mask_en),
    .word     (in_word),
    .vsel     (in_vsel),
    .byte_sel (byte_sel),
    .span     (span)
  );

  vcmp_pack u_pack (
    .src      (in_src),
    .byte_sel (byte_sel),
    .packed_q (packed_q),
    .pk_bytes (pk_bytes)
  );

  vcmp_tail u_tail (
    .packed_q   (packed_q),
    .old        (in_old),
    .pk_bytes   (pk_bytes),
    .span       (span),
    .zero       (in_zero),
    .result     (c_result),
    .store_data (c_store),
    .byte_en    (c_be)
  );

  assign c_cnt = in_word ? (pk_bytes >> 1) : pk_bytes;

  // output stage: next-state then registers
  logic                 r_valid, nxt_valid;
  logic [VEC_BITS-1:0]  r_result, nxt_result;
  logic [VEC_BITS-1:0]  r_store, nxt_store;
  logic [VEC_BYTES-1:0] r_be, nxt_be;
  cnt_t                 r_cnt, nxt_cnt;
  logic                 r_word, nxt_word;
  logic [1:0]           r_vsel, nxt_vsel;
  logic                 r_zero, nxt_zero;

  always_comb begin
    nxt_valid  = in_valid;
    nxt_result = r_result;
    nxt_store  = r_store;
    nxt_be     = r_be;
    nxt_cnt    = r_cnt;
    nxt_word   = r_word;
    nxt_vsel   = r_vsel;
    nxt_zero   = r_zero;
    if (in_valid) begin
      nxt_result = c_result;
      nxt_store  = c_store;
      nxt_be     = c_be;
      nxt_cnt    = c_cnt;
      nxt_word   = in_word;
      nxt_vsel   = in_vsel;
      nxt_zero   = in_zero;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_valid  <= 1'b0;
      r_result <= '0;
      r_store  <= '0;
      r_be     <= '0;
      r_cnt    <= '0;
      r_word   <= 1'b0;
      r_vsel   <= 2'd0;
      r_zero   <= 1'b0;
    end else begin
      r_valid  <= nxt_valid;
      r_result <= nxt_result;
      r_store  <= nxt_store;
      r_be     <= nxt_be;
      r_cnt    <= nxt_cnt;
      r_word   <= nxt_word;
      r_vsel   <= nxt_vsel;
      r_zero   <= nxt_zero;
    end
  end

  assign out_valid      = r_valid;
  assign out_result     = r_result;
  assign out_store_data = r_store;
  assign out_byte_en    = r_be;
  assign out_count      = r_cnt;

  // bit-level views of the registered enables and span for the checks below
  logic [VEC_BITS-1:0] en_bits;
  logic [VEC_BITS-1:0] span_bits;
  cnt_t                r_span;
  assign r_span = span_bytes(r_vsel);
  for (genvar g = 0; g < VEC_BYTES; g++) begin : g_view
    assign en_bits[g*8 +: 8]   = {8{out_byte_en[g]}};
    assign span_bits[g*8 +: 8] = {8{cnt_t'(g) < r_span}};
  end

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R10
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_result) && $stable(out_count) && $stable(out_byte_en)));
  // R7
  be_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_byte_en & (out_byte_en + 1'b1)) == '0));
  // R8
  be_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_byte_en) ==
                   (r_word ? 2 * int'(out_count) : int'(out_count))));
  // R2
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_count <= (r_span >> r_word)));
  // R6
  above_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_result & ~span_bits) == '0));
  // R5
  zero_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && r_zero) |-> ((out_result & ~en_bits) == '0));
  // R1
  forms_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (((out_result ^ out_store_data) & en_bits) == '0));
  // R7
  store_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_store_data & ~en_bits) == '0));
endmodule

// File: tb/tb_vcompress_unit.sv
module tb_vcompress_unit;
  import vcmp_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n;
  logic           in_valid;
  logic [511:0]   in_src, in_old;
  logic [63:0]    in_mask;
  logic           in_mask_en, in_word, in_zero;
  logic [1:0]     in_vsel;
  logic           out_valid;
  logic [511:0]   out_result, out_store_data;
  logic [63:0]    out_byte_en;
  logic [6:0]     out_count;

  vcompress_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src(in_src), .in_old(in_old),
    .in_mask(in_mask), .in_mask_en(in_mask_en), .in_word(in_word), .in_vsel(in_vsel),
    .in_zero(in_zero), .out_valid(out_valid), .out_result(out_result),
    .out_store_data(out_store_data), .out_byte_en(out_byte_en), .out_count(out_count)
  );

  int n_checks = 0;
  int n_err    = 0;
  bit finished = 0;

  logic [511:0] exp_res, exp_st, pk_bits, span_bits;
  logic [63:0]  exp_be;
  int           exp_cnt;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // element-wise reference model
  task automatic model(input bit word, input int vs, input bit zero, input bit men,
                       input logic [63:0] mask, input logic [511:0] src,
                       input logic [511:0] old);
    int eb = word ? 2 : 1;
    int nb = (vs == 0) ? 16 : (vs == 1) ? 32 : 64;
    int ne = nb / eb;
    int k  = 0;
    int nbytes;
    logic [511:0] pk = '0;
    for (int j = 0; j < ne; j++) begin
      if (!men || mask[j]) begin
        for (int e = 0; e < eb; e++) pk[(k*eb+e)*8 +: 8] = src[(j*eb+e)*8 +: 8];
        k++;
      end
    end
    exp_cnt = k;
    nbytes  = k * eb;
    for (int b = 0; b < 64; b++) begin
      exp_be[b]            = (b < nbytes);
      pk_bits[b*8 +: 8]    = (b < nbytes) ? 8'hFF : 8'h00;
      span_bits[b*8 +: 8]  = (b < nb) ? 8'hFF : 8'h00;
      exp_st[b*8 +: 8]     = (b < nbytes) ? pk[b*8 +: 8] : 8'h00;
      exp_res[b*8 +: 8]    = (b < nbytes) ? pk[b*8 +: 8] :
                             (b < nb && !zero) ? old[b*8 +: 8] : 8'h00;
    end
  endtask

  task automatic run_one(input bit word, input int vs, input bit zero, input bit men,
                         input logic [63:0] mask, input int seed, input string tag);
    logic [511:0] s, o;
    for (int b = 0; b < 64; b++) begin
      s[b*8 +: 8] = 8'((b * 37 + seed * 11 + 1));
      o[b*8 +: 8] = 8'((8'hA0 ^ b ^ seed));
    end
    @(negedge clk);
    in_src = s; in_old = o; in_mask = mask; in_mask_en = men;
    in_word = word; in_vsel = 2'(vs); in_zero = zero; in_valid = 1'b1;
    model(word, vs, zero, men, mask, s, o);
    @(negedge clk);
    in_valid = 1'b0;
    in_src = ~s; in_old = ~o; in_mask = ~mask; in_zero = ~zero;
    chk(out_valid === 1'b1, "R10", "valid after strobe", 512'(out_valid), 512'(1));
    chk((out_result & pk_bits) === (exp_res & pk_bits), tag, "packed region",
        out_result & pk_bits, exp_res & pk_bits);
    chk((out_result & span_bits & ~pk_bits) === (exp_res & span_bits & ~pk_bits),
        zero ? "R5" : "R4", "tail region",
        out_result & span_bits & ~pk_bits, exp_res & span_bits & ~pk_bits);
    chk((out_result & ~span_bits) === '0, "R6", "above span", out_result & ~span_bits, '0);
    chk(out_byte_en === exp_be, "R7", "byte enables", 512'(out_byte_en), 512'(exp_be));
    chk(out_store_data === exp_st, "R7", "store data", out_store_data, exp_st);
    chk(int'(out_count) == exp_cnt, (tag == "R2") ? "R2" : "R8", "count",
        512'(out_count), 512'(exp_cnt));
    // idle cycle: outputs must hold while inputs change
    @(negedge clk);
    chk(out_valid === 1'b0, "R10", "valid drops", 512'(out_valid), '0);
    chk(out_result === exp_res, "R10", "result held", out_result, exp_res);
  endtask

  initial begin
    logic [63:0] lf = 64'h9E37_79B9_7F4A_7C15;
    rst_n = 1'b0; in_valid = 1'b0; in_src = '0; in_old = '0; in_mask = '0;
    in_mask_en = 1'b1; in_word = 1'b0; in_vsel = 2'd0; in_zero = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R10", "reset valid", 512'(out_valid), '0);
    chk(out_count === 7'd0 && out_byte_en === '0, "R10", "reset count/enables",
        512'({out_count, out_byte_en}), '0);
    chk(out_result === '0 && out_store_data === '0, "R10", "reset data",
        out_result | out_store_data, '0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int w = 0; w < 2; w++) begin
      for (int vs = 0; vs < 3; vs++) begin
        for (int z = 0; z < 2; z++) begin
          int ne = ((vs == 0) ? 16 : (vs == 1) ? 32 : 64) / (w + 1);
          run_one(w[0], vs, z[0], 1'b1, 64'h0, 1, "R9");
          run_one(w[0], vs, z[0], 1'b1, '1, 2, "R1");
          run_one(w[0], vs, z[0], 1'b1, {16{4'h5}}, 3, "R1");
          run_one(w[0], vs, z[0], 1'b1, {16{4'hA}}, 4, "R1");
          for (int i = 0; i < 64; i++)
            run_one(w[0], vs, z[0], 1'b1, 64'(1) << i, i + 5,
                    (i >= ne) ? "R2" : "R1");
          for (int r = 0; r < 32; r++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 7); lf = lf ^ (lf << 17);
            run_one(w[0], vs, z[0], 1'b1, lf, r + 70, "R1");
          end
          for (int r = 0; r < 4; r++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 7); lf = lf ^ (lf << 17);
            run_one(w[0], vs, z[0], 1'b0, lf, r + 110, "R3");
          end
        end
      end
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_err++;
      $display("FAIL R10 watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule